// File: doc/BRIEF.md
# Multi-Mode PWM Timebase and Action Generator

This block drives two pulse-width-modulated outputs, A and B, from a single time-base counter. A two-stage clock-enable prescaler sets the tick rate. On each tick the counter steps in one of three patterns against a programmable period: rising with wrap, falling with reload, or rising then falling. The counter raises a zero event and a period event. Four compare slots raise match events whenever the counter equals their active value.

Each output has an action table. The table maps the zero event, the period event and the compare-0/compare-1 matches (the last two split by counting direction) onto one of four actions: hold, clear, set or toggle. The period and all compare values are written into shadow copies. Each shadow reaches its active register at a selectable point in the count, so software may update them at any time without producing a torn cycle. Compare slots 2 and 3 drive no action. Their matches are brought out as event pulses.

A single-cycle write port programs the block. Registers: 0 control, 1 period shadow, 2..5 compare shadows 0..3, 6 reload selection, 7 action table A, 8 action table B.

Top module: `pwm_tbgen`

## Requirements
- R1: Synchronous active-high reset leaves pwm_a, pwm_b, cnt_o and every event output at 0, all registers cleared, and the counter stopped. Control register fields are: mode in bits [1:0] (0 stop, 1 up, 2 down, 3 up-down), power-of-two divider exponent E in bits [4:2], high-speed divider H in bits [7:5], and immediate period load in bit 8.
- R2: The counter steps only on a tick. A tick occurs once every 2^E × (H+1) clocks.
- R3: In up mode the count runs 0,1,…,P and then wraps to 0, where P is the active period. One cycle is P+1 ticks.
- R4: In down mode the count runs P,P-1,…,0 and then reloads P. One cycle is P+1 ticks.
- R5: In up-down mode the count rises from 0 to P and then falls back to 0. One cycle is 2×P ticks.
- R6: zero_evt pulses for one clock after a tick on which the count was 0. prd_evt pulses for one clock after a tick on which the count equalled P. No events are raised while the counter is stopped.
- R7: A write of a new mode, including stop, takes effect only on a tick at which the count is 0.
- R8: With control bit 8 set, a period write updates the active period at once. With bit 8 clear, the shadow is copied to the active period on a zero event.
- R9: The reload register holds two bits per compare slot i, at bits [2i+1:2i]. The codes are: 0 reload on zero event, 1 on period event, 2 on either, 3 immediately on write. A match uses the active value held before any reload on the same tick.
- R10: cmp_evt[i] pulses for one clock after a running tick on which the count equalled the active value of compare slot i.
- R11: Each action table holds 2-bit codes (0 hold, 1 clear, 2 set, 3 toggle). The fields are: zero [1:0], period [3:2], compare-0 up [5:4], compare-0 down [7:6], compare-1 up [9:8], compare-1 down [11:10]. The output changes one clock after the tick.
- R12: Compare entries use the up field in up mode and the down field in down mode. In up-down mode they use the direction that led to the current count, which is up at the peak and down on arrival at 0, except on the first tick after start.
- R13: When several events fire on one tick, the winner is the first non-hold action in this order: compare-1, compare-0, period, zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register index |
| wr_data | input | CNT_W | Write data |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |
| cnt_o | output | CNT_W | Current counter value |
| zero_evt | output | 1 | Zero event pulse |
| prd_evt | output | 1 | Period event pulse |
| cmp_evt | output | NCMP | Compare match pulses |

## Verification
The hardest situations to reach are the ones where several things coincide. One is a shadow reload landing on the same tick as a match. Another is a mode change pending until the counter reaches zero. A third is several events firing on one tick. The stimulus writes the shadows mid-cycle under each of the four reload codes. It requests a mode change while the count is far from zero. It places compare-0 and compare-1 both at 0 so that they fire together with the zero event, in up mode and again in up-down mode. The prescaler runs with a non-trivial divider during part of the run, so that off-tick clocks also face the per-clock reference comparison.

// File: rtl/pwm_tbgen_pkg.sv
package pwm_tbgen_pkg;
  localparam logic [1:0] MODE_STOP = 2'd0;
  localparam logic [1:0] MODE_UP   = 2'd1;
  localparam logic [1:0] MODE_DOWN = 2'd2;
  localparam logic [1:0] MODE_UPDN = 2'd3;

  localparam logic [1:0] ACT_HOLD = 2'd0;
  localparam logic [1:0] ACT_CLR  = 2'd1;
  localparam logic [1:0] ACT_SET  = 2'd2;
  localparam logic [1:0] ACT_TGL  = 2'd3;

  localparam logic [1:0] LD_ZERO = 2'd0;
  localparam logic [1:0] LD_PRD  = 2'd1;
  localparam logic [1:0] LD_BOTH = 2'd2;
  localparam logic [1:0] LD_IMM  = 2'd3;

  localparam int TBL_W = 12;
  localparam int F_ZRO = 0;
  localparam int F_PRD = 2;
  localparam int F_C0U = 4;
  localparam int F_C0D = 6;
  localparam int F_C1U = 8;
  localparam int F_C1D = 10;

  localparam int A_CTRL = 0;
  localparam int A_PRD  = 1;
  localparam int A_CMP0 = 2;
endpackage

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int EXP_W = 3,
  parameter int HS_W  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [HS_W-1:0]  hs_i,
  output logic             tick_o
);
  localparam int C1_W = (1 << EXP_W) - 1;

  logic [C1_W-1:0] c1_q;
  logic [C1_W-1:0] lim;
  logic [HS_W-1:0] c2_q;
  logic            c1_end;

  assign lim    = ~({C1_W{1'b1}} << exp_i);
  assign c1_end = (c1_q >= lim);
  assign tick_o = c1_end && (c2_q >= hs_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      c1_q <= '0;
      c2_q <= '0;
    end else if (c1_end) begin
      c1_q <= '0;
      c2_q <= (c2_q >= hs_i) ? '0 : c2_q + 1'b1;
    end else begin
      c1_q <= c1_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_tbgen_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [1:0]       cfg_mode,
  input  logic [CNT_W-1:0] prd_i,
  output logic [CNT_W-1:0] cnt_q,
  output logic             run,
  output logic             zero_hit,
  output logic             prd_hit,
  output logic             dir_eff
);
  logic [1:0]       act_mode_q;
  logic [1:0]       eff_mode;
  logic             dir_q;
  logic             dir_nx;
  logic [CNT_W-1:0] cnt_nx;
  logic             at_zero;

  assign at_zero  = (cnt_q == '0);
  assign eff_mode = at_zero ? cfg_mode : act_mode_q;
  assign run      = tick && (eff_mode != MODE_STOP);
  assign zero_hit = run && at_zero;
  assign prd_hit  = run && (cnt_q == prd_i);
  assign dir_eff  = (eff_mode == MODE_UP)   ? 1'b1 :
                    (eff_mode == MODE_DOWN) ? 1'b0 : dir_q;

  always_comb begin
    cnt_nx = cnt_q;
    dir_nx = dir_q;
    case (eff_mode)
      MODE_UP: begin
        cnt_nx = (cnt_q >= prd_i) ? '0 : cnt_q + 1'b1;
        dir_nx = 1'b1;
      end
      MODE_DOWN: begin
        cnt_nx = at_zero ? prd_i : cnt_q - 1'b1;
        dir_nx = 1'b0;
      end
      MODE_UPDN: begin
        if (at_zero) begin
          cnt_nx = (prd_i == '0) ? '0 : {{(CNT_W-1){1'b0}}, 1'b1};
          dir_nx = 1'b1;
        end else if (dir_q && cnt_q >= prd_i) begin
          cnt_nx = cnt_q - 1'b1;
          dir_nx = 1'b0;
        end else begin
          cnt_nx = dir_q ? cnt_q + 1'b1 : cnt_q - 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      dir_q      <= 1'b1;
      act_mode_q <= MODE_STOP;
    end else if (tick) begin
      cnt_q      <= cnt_nx;
      dir_q      <= dir_nx;
      act_mode_q <= eff_mode;
    end
  end

  // R2: the count is frozen between ticks
  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));

  // R5: up-down mode moves by exactly one step per tick
  a_r5_unit_step: assert property (@(posedge clk) disable iff (rst)
    (tick && eff_mode == MODE_UPDN && prd_i != '0) |=>
      ((cnt_q - $past(cnt_q)) == {{(CNT_W-1){1'b0}}, 1'b1}) ||
      (($past(cnt_q) - cnt_q) == {{(CNT_W-1){1'b0}}, 1'b1}));

  // R7: the running mode only changes on a tick at count zero
  a_r7_mode_at_zero: assert property (@(posedge clk) disable iff (rst)
    !(tick && at_zero) |=> $stable(act_mode_q));
endmodule

// File: rtl/pwm_cmpbank.sv
module pwm_cmpbank
  import pwm_tbgen_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int NCMP  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCMP-1:0]   wr_sel,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [2*NCMP-1:0] ld_sel,
  input  logic              run,
  input  logic              zero_hit,
  input  logic              prd_hit,
  input  logic [CNT_W-1:0]  cnt,
  output logic [NCMP-1:0]   match
);
  for (genvar i = 0; i < NCMP; i++) begin : g_slot
    logic [CNT_W-1:0] sh_q;
    logic [CNT_W-1:0] act_q;
    logic [1:0]       sel;
    logic             ld_evt;

    assign sel = ld_sel[2*i +: 2];
    always_comb begin
      case (sel)
        LD_ZERO: ld_evt = zero_hit;
        LD_PRD:  ld_evt = prd_hit;
        LD_BOTH: ld_evt = zero_hit || prd_hit;
        default: ld_evt = 1'b0;
      endcase
    end

    assign match[i] = run && (cnt == act_q);

    always_ff @(posedge clk) begin
      if (rst) begin
        sh_q  <= '0;
        act_q <= '0;
      end else begin
        if (ld_evt) act_q <= sh_q;
        if (wr_sel[i]) begin
          sh_q <= wr_data;
          if (sel == LD_IMM) act_q <= wr_data;
        end
      end
    end

    // R9: immediate reload makes the written value active on the next clock
    a_r9_imm_follow: assert property (@(posedge clk) disable iff (rst)
      (wr_sel[i] && sel == LD_IMM) |=> (act_q == $past(wr_data)));
  end
endmodule

// File: rtl/pwm_action.sv
module pwm_action
  import pwm_tbgen_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             zero_hit,
  input  logic             prd_hit,
  input  logic             c0_hit,
  input  logic             c1_hit,
  input  logic             dir,
  input  logic [TBL_W-1:0] tbl,
  output logic             pwm_q
);
  logic [1:0] a_c1, a_c0, a_p, a_z, win;

  assign a_c1 = !c1_hit ? ACT_HOLD : dir ? tbl[F_C1U +: 2] : tbl[F_C1D +: 2];
  assign a_c0 = !c0_hit ? ACT_HOLD : dir ? tbl[F_C0U +: 2] : tbl[F_C0D +: 2];
  assign a_p  = prd_hit  ? tbl[F_PRD +: 2] : ACT_HOLD;
  assign a_z  = zero_hit ? tbl[F_ZRO +: 2] : ACT_HOLD;

  always_comb begin
    if      (a_c1 != ACT_HOLD) win = a_c1;
    else if (a_c0 != ACT_HOLD) win = a_c0;
    else if (a_p  != ACT_HOLD) win = a_p;
    else                       win = a_z;
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_q <= 1'b0;
    else begin
      case (win)
        ACT_CLR: pwm_q <= 1'b0;
        ACT_SET: pwm_q <= 1'b1;
        ACT_TGL: pwm_q <= ~pwm_q;
        default: ;
      endcase
    end
  end

  // R13: with no event on this clock the output holds
  a_r13_quiet_hold: assert property (@(posedge clk) disable iff (rst)
    !(zero_hit || prd_hit || c0_hit || c1_hit) |=> $stable(pwm_q));
endmodule

// File: rtl/pwm_tbgen.sv
module pwm_tbgen
  import pwm_tbgen_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4,
  parameter int EXP_W  = 3,
  parameter int HS_W   = 3,
  parameter int NCMP   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic              pwm_a,
  output logic              pwm_b,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              zero_evt,
  output logic              prd_evt,
  output logic [NCMP-1:0]   cmp_evt
);
  localparam int NOUT    = 2;
  localparam int CTRL_W  = 3 + EXP_W + HS_W;
  localparam int EXP_LSB = 2;
  localparam int HS_LSB  = EXP_LSB + EXP_W;
  localparam int IMM_BIT = HS_LSB + HS_W;
  localparam int A_LDSEL = A_CMP0 + NCMP;
  localparam int A_ACT0  = A_LDSEL + 1;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  prd_sh_q, prd_act_q;
  logic [2*NCMP-1:0] ldsel_q;
  logic [TBL_W-1:0]  tbl_q [NOUT];
  logic [NOUT-1:0]   pwm_w;
  logic [NCMP-1:0]   wr_cmp, match;
  logic              tick, run, zero_hit, prd_hit, dir_eff, imm;

  assign imm = ctrl_q[IMM_BIT];

  pwm_prescale #(.EXP_W(EXP_W), .HS_W(HS_W)) u_pre (
    .clk(clk), .rst(rst),
    .exp_i(ctrl_q[EXP_LSB +: EXP_W]), .hs_i(ctrl_q[HS_LSB +: HS_W]),
    .tick_o(tick));

  pwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst(rst), .tick(tick), .cfg_mode(ctrl_q[1:0]),
    .prd_i(prd_act_q), .cnt_q(cnt_o), .run(run), .zero_hit(zero_hit),
    .prd_hit(prd_hit), .dir_eff(dir_eff));

  for (genvar i = 0; i < NCMP; i++) begin : g_wsel
    assign wr_cmp[i] = wr_en && (wr_addr == ADDR_W'(A_CMP0 + i));
  end

  pwm_cmpbank #(.CNT_W(CNT_W), .NCMP(NCMP)) u_cmp (
    .clk(clk), .rst(rst), .wr_sel(wr_cmp), .wr_data(wr_data),
    .ld_sel(ldsel_q), .run(run), .zero_hit(zero_hit), .prd_hit(prd_hit),
    .cnt(cnt_o), .match(match));

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    pwm_action u_act (
      .clk(clk), .rst(rst), .zero_hit(zero_hit), .prd_hit(prd_hit),
      .c0_hit(match[0]), .c1_hit(match[1]), .dir(dir_eff),
      .tbl(tbl_q[g]), .pwm_q(pwm_w[g]));

    always_ff @(posedge clk) begin
      if (rst) tbl_q[g] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(A_ACT0 + g)) tbl_q[g] <= wr_data[TBL_W-1:0];
    end
  end

  assign pwm_a = pwm_w[0];
  assign pwm_b = pwm_w[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      ldsel_q   <= '0;
      prd_sh_q  <= '0;
      prd_act_q <= '0;
      zero_evt  <= 1'b0;
      prd_evt   <= 1'b0;
      cmp_evt   <= '0;
    end else begin
      zero_evt <= zero_hit;
      prd_evt  <= prd_hit;
      cmp_evt  <= match;
      if (wr_en && wr_addr == ADDR_W'(A_CTRL))  ctrl_q  <= wr_data[CTRL_W-1:0];
      if (wr_en && wr_addr == ADDR_W'(A_LDSEL)) ldsel_q <= wr_data[2*NCMP-1:0];
      if (zero_hit && !imm) prd_act_q <= prd_sh_q;
      if (wr_en && wr_addr == ADDR_W'(A_PRD)) begin
        prd_sh_q <= wr_data;
        if (imm) prd_act_q <= wr_data;
      end
    end
  end

  // R10: event pulses only follow a tick
  a_r10_evt_on_tick: assert property (@(posedge clk) disable iff (rst)
    (zero_evt || prd_evt || (|cmp_evt)) |-> $past(tick));
endmodule

// File: tb/pwm_tbgen_tb.sv
module pwm_tbgen_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [15:0] wr_data;
  logic        pwm_a, pwm_b, zero_evt, prd_evt;
  logic [15:0] cnt_o;
  logic [3:0]  cmp_evt;

  always #5 clk = ~clk;

  pwm_tbgen u_dut (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b), .cnt_o(cnt_o),
    .zero_evt(zero_evt), .prd_evt(prd_evt), .cmp_evt(cmp_evt));

  int vectors = 0, fails = 0;
  bit started = 0, done = 0;
  string cur = "R1";

  // behavioural reference state
  int m_ctrl, m_ld, m_ta, m_tb, m_c1, m_c2, m_cnt, m_dir, m_mode, m_prd, m_prd_sh;
  int m_cmp[4], m_csh[4];
  logic m_pa, m_pb, m_ez, m_ep;
  logic [3:0] m_ec;

  function automatic logic act_next(int tbl, bit z, bit p, bit c0, bit c1, bit d, logic now);
    int code = 0;
    if (c1) code = (tbl >> (d ? 8 : 10)) & 3;
    if (code == 0 && c0) code = (tbl >> (d ? 4 : 6)) & 3;
    if (code == 0 && p) code = (tbl >> 2) & 3;
    if (code == 0 && z) code = tbl & 3;
    case (code)
      1: return 1'b0;
      2: return 1'b1;
      3: return ~now;
      default: return now;
    endcase
  endfunction

  always @(posedge clk) begin : model
    int e, h, lim, m, nxt, nd, sel;
    bit tk, rn, z, p, d, ldv;
    bit mt[4];
    started <= 1;
    if (rst) begin
      m_ctrl = 0; m_ld = 0; m_ta = 0; m_tb = 0; m_c1 = 0; m_c2 = 0; m_cnt = 0;
      m_dir = 1; m_mode = 0; m_prd = 0; m_prd_sh = 0;
      foreach (m_cmp[i]) begin m_cmp[i] = 0; m_csh[i] = 0; end
      m_pa = 0; m_pb = 0; m_ez = 0; m_ep = 0; m_ec = 0;
    end else begin
      e = (m_ctrl >> 2) & 7; h = (m_ctrl >> 5) & 7; lim = (1 << e) - 1;
      tk = (m_c1 >= lim) && (m_c2 >= h);
      if (m_c1 >= lim) begin m_c1 = 0; m_c2 = (m_c2 >= h) ? 0 : m_c2 + 1; end
      else m_c1++;
      m_ez = 0; m_ep = 0; m_ec = 0;
      if (tk) begin
        m = (m_cnt == 0) ? (m_ctrl & 3) : m_mode;
        rn = (m != 0);
        d = (m == 1) ? 1 : (m == 2) ? 0 : m_dir[0];
        z = rn && m_cnt == 0; p = rn && m_cnt == m_prd;
        for (int i = 0; i < 4; i++) mt[i] = rn && m_cnt == m_cmp[i];
        nxt = m_cnt; nd = m_dir;
        if (m == 1) begin nxt = (m_cnt >= m_prd) ? 0 : m_cnt + 1; nd = 1; end
        else if (m == 2) begin nxt = (m_cnt == 0) ? m_prd : m_cnt - 1; nd = 0; end
        else if (m == 3) begin
          if (m_cnt == 0) begin nxt = (m_prd == 0) ? 0 : 1; nd = 1; end
          else if (m_dir == 1 && m_cnt >= m_prd) begin nxt = m_cnt - 1; nd = 0; end
          else nxt = (m_dir == 1) ? m_cnt + 1 : m_cnt - 1;
        end
        m_pa = act_next(m_ta, z, p, mt[0], mt[1], d, m_pa);
        m_pb = act_next(m_tb, z, p, mt[0], mt[1], d, m_pb);
        if (z && ((m_ctrl >> 8) & 1) == 0) m_prd = m_prd_sh;
        for (int i = 0; i < 4; i++) begin
          sel = (m_ld >> (2 * i)) & 3;
          ldv = (sel == 0 && z) || (sel == 1 && p) || (sel == 2 && (z || p));
          if (ldv) m_cmp[i] = m_csh[i];
          m_ec[i] = mt[i];
        end
        m_ez = z; m_ep = p; m_mode = m; m_cnt = nxt; m_dir = nd;
      end
      if (wr_en) begin
        case (int'(wr_addr))
          0: m_ctrl = int'(wr_data) & 16'h1FF;
          1: begin m_prd_sh = int'(wr_data); if (((m_ctrl >> 8) & 1) == 1) m_prd = int'(wr_data); end
          2, 3, 4, 5: begin
            m_csh[int'(wr_addr) - 2] = int'(wr_data);
            if (((m_ld >> (2 * (int'(wr_addr) - 2))) & 3) == 3) m_cmp[int'(wr_addr) - 2] = int'(wr_data);
          end
          6: m_ld = int'(wr_data) & 8'hFF;
          7: m_ta = int'(wr_data) & 12'hFFF;
          8: m_tb = int'(wr_data) & 12'hFFF;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    bit bad;
    if (started && !done) begin
      vectors++;
      bad = 0;
      if (pwm_a !== m_pa) begin bad = 1; $display("FAIL %s pwm_a got %b exp %b", cur, pwm_a, m_pa); end
      if (pwm_b !== m_pb) begin bad = 1; $display("FAIL %s pwm_b got %b exp %b", cur, pwm_b, m_pb); end
      if (cnt_o !== 16'(m_cnt)) begin bad = 1; $display("FAIL %s cnt_o got %0d exp %0d", cur, cnt_o, m_cnt); end
      if (zero_evt !== m_ez) begin bad = 1; $display("FAIL %s zero_evt got %b exp %b", cur, zero_evt, m_ez); end
      if (prd_evt !== m_ep) begin bad = 1; $display("FAIL %s prd_evt got %b exp %b", cur, prd_evt, m_ep); end
      if (cmp_evt !== m_ec) begin bad = 1; $display("FAIL %s cmp_evt got %b exp %b", cur, cmp_evt, m_ec); end
      if (bad) fails++;
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    run(4);
    rst = 1'b0;
    cur = "R1";  run(10);                         // reset state, stopped
    cur = "R8";  wr(0, 'h100); wr(1, 9);          // immediate period load
    wr(6, 'hFF);                                  // all compares immediate
    wr(2, 3); wr(3, 6); wr(4, 5); wr(5, 0);
    cur = "R11"; wr(7, 'h012); wr(8, 'h20D);      // A: zero set, c0 up clear
    cur = "R3";  wr(0, 1); run(40);               // up mode, period at zero
    cur = "R8";  wr(1, 5); run(30);               // shadow period lands on zero
    cur = "R2";  wr(0, 1 | (1 << 2) | (2 << 5)); run(120);
    cur = "R7";  wr(0, 2 | (1 << 2) | (2 << 5)); run(40);
    cur = "R4";  run(60);
    cur = "R12"; wr(7, 'h0A0); wr(8, 'hF01); wr(0, 3); run(60);
    cur = "R5";  run(40);
    cur = "R9";  wr(6, 'hE4);
    wr(2, 2); run(3); wr(3, 4); run(5); wr(4, 1); run(2); wr(5, 3); run(40);
    cur = "R10"; run(30);
    cur = "R13"; wr(6, 'hFF); wr(2, 0); wr(3, 0);
    wr(7, 'hF52); wr(8, 'h052); wr(0, 1); run(40);
    wr(0, 3); run(40);
    cur = "R6";  wr(0, 3 | (2 << 2)); run(80);
    cur = "R7";  wr(0, 0); run(80);               // stop takes effect at zero
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired in %s", cur);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule